// File: doc/BRIEF.md
# Snooping Coherent Direct-Mapped Data Cache

This block is a small write-back data cache for one core in a multi-core system where the caches share one bus. Each slot is direct-mapped and has a tag, a full line of data, and a two-bit coherence state: Invalid, Shared, Exclusive or Modified. The core issues one load or store at a time with a valid/ready handshake. A store can have byte enables.

The bus side has a request/grant pair. Through it the cache issues four line-granular commands: read, read-for-ownership, upgrade and write-back. An external arbiter runs one transaction at a time. It presents each transaction to every other cache on that cache's snoop port and then finishes the transaction with `bus_done_i`. One cycle after a snoop, the cache answers with a shared flag and, if its copy is dirty, the full line. A cache that holds a line Exclusive or Modified can write it without any bus traffic. A cache that holds a line Shared or not at all must win the bus before its data changes.

Top module: `cc_mesi_cache`

## Requirements
- R1: After reset every slot is Invalid (state code I=00, S=01, E=10, M=11). `core_ready_o` and `bus_req_o` are low, and the first access to any address misses and raises a bus request.
- R2: A load miss requests the whole line with command 00 (read). `bus_addr_o` carries the byte address without its line-offset bits. The load completes only after `bus_done_i`. Word k of a line occupies bus bits [k*WORD_W +: WORD_W]. Later loads to other words of the same line complete with no bus request.
- R3: A line filled by a read becomes Exclusive if `bus_shared_i` is low at completion, and Shared if it is high.
- R4: A store to a line held Exclusive or Modified completes without a bus request and leaves the line Modified.
- R5: A store miss requests command 01 (read for ownership). A store to a Shared line requests command 10 (upgrade). The stored word changes only after that request's `bus_done_i`.
- R6: One cycle after `snp_valid_i` with command 00, 01 or 10 hitting a valid line, `snp_shared_o` is high. If that line is Modified and the command is 00 or 01, `snp_dirty_o` is also high and `snp_data_o` holds the whole line. In every other cycle both flags are low.
- R7: A snooped 00 that hits an Exclusive or Modified line leaves it Shared. A snooped 01 or 10 that hits a line makes it Invalid. Command 11 is ignored by the snoop logic.
- R8: If a miss maps to a slot that holds a Modified line with a different tag, the cache first writes that line back with command 11, the victim's line address and its full data. It then issues its own fill request.
- R9: Store byte-enable bit b selects bits [8b+7:8b] of the word. Only the selected bytes change.
- R10: Once raised, `bus_req_o` stays high until `bus_gnt_i`. If a snoop invalidates the pending line while the cache waits for grant, a pending upgrade becomes a read-for-ownership.
- R11: `core_ready_o` pulses for exactly one cycle per accepted request. For a load, `core_rdata_o` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_valid_i | input | 1 | Core request valid, held until ready |
| core_we_i | input | 1 | 1 = store, 0 = load |
| core_addr_i | input | ADDR_W | Byte address |
| core_wdata_i | input | WORD_W | Store data |
| core_be_i | input | WORD_W/8 | Store byte enables |
| core_ready_o | output | 1 | One-cycle completion pulse |
| core_rdata_o | output | WORD_W | Load data, valid with ready |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant, one cycle |
| bus_cmd_o | output | 2 | 00 read, 01 read-for-ownership, 10 upgrade, 11 write-back |
| bus_addr_o | output | ADDR_W-OFF_W | Line address of the request |
| bus_wdata_o | output | LINE_W | Line data for a write-back |
| bus_done_i | input | 1 | Transaction complete, one cycle |
| bus_rdata_i | input | LINE_W | Fill data, valid with done |
| bus_shared_i | input | 1 | Another cache holds the line, valid with done |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_cmd_i | input | 2 | Snooped command |
| snp_addr_i | input | ADDR_W-OFF_W | Snooped line address |
| snp_shared_o | output | 1 | Snoop hit a valid line (one cycle later) |
| snp_dirty_o | output | 1 | Dirty data supplied (one cycle later) |
| snp_data_o | output | LINE_W | Supplied line data |

## Verification
A state that is too strong shows up as a store that finishes with no bus request while another cache still holds the line. The other cache's next load of that line then returns stale data as soon as it completes. A state that is too weak shows up as an extra upgrade or read command in the bus log on the next access. A lost Modified line shows up as stale memory when the line is evicted, or when another cache reads it and gets no dirty data in the cycle after its snoop. Two caches run against one shared memory model, so each of these mistakes becomes visible within a few accesses.

// File: rtl/cc_pkg.sv
package cc_pkg;
    typedef enum logic [1:0] {
        MESI_I = 2'b00,
        MESI_S = 2'b01,
        MESI_E = 2'b10,
        MESI_M = 2'b11
    } mesi_e;

    typedef enum logic [1:0] {
        CMD_RD  = 2'b00,
        CMD_RDX = 2'b01,
        CMD_UPG = 2'b10,
        CMD_WB  = 2'b11
    } bus_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOOK = 3'd1,
        ST_REQ  = 3'd2,
        ST_WAIT = 3'd3,
        ST_RESP = 3'd4
    } ctl_e;
endpackage

// File: rtl/cc_merge.sv
module cc_merge #(
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4
) (
    input  logic [WORD_W*LINE_WORDS-1:0]      line_i,
    input  logic [$clog2(LINE_WORDS)-1:0]     word_i,
    input  logic [WORD_W-1:0]                 wdata_i,
    input  logic [WORD_W/8-1:0]               be_i,
    output logic [WORD_W*LINE_WORDS-1:0]      line_o
);
    localparam int BYTES_W = WORD_W / 8;

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        for (genvar b = 0; b < BYTES_W; b++) begin : g_byte
            assign line_o[w*WORD_W + b*8 +: 8] =
                ((int'(word_i) == w) && be_i[b]) ? wdata_i[b*8 +: 8]
                                                 : line_i[w*WORD_W + b*8 +: 8];
        end
    end
endmodule

// File: rtl/cc_cmd_sel.sv
module cc_cmd_sel
    import cc_pkg::*;
#(
    parameter int TAG_W = 9
) (
    input  logic [1:0]       line_st_i,
    input  logic [TAG_W-1:0] line_tag_i,
    input  logic [TAG_W-1:0] req_tag_i,
    input  logic             req_we_i,
    output logic             hit_o,
    output logic             writable_o,
    output logic             victim_o,
    output logic [1:0]       cmd_o
);
    logic  present;
    logic  tag_eq;
    mesi_e st;

    always_comb begin
        st         = mesi_e'(line_st_i);
        present    = (st != MESI_I);
        tag_eq     = (line_tag_i == req_tag_i);
        hit_o      = present && tag_eq;
        writable_o = hit_o && ((st == MESI_E) || (st == MESI_M));
        victim_o   = present && !tag_eq && (st == MESI_M);
        if (victim_o) begin
            cmd_o = CMD_WB;
        end else if (hit_o && (st == MESI_S)) begin
            cmd_o = CMD_UPG;
        end else begin
            cmd_o = req_we_i ? CMD_RDX : CMD_RD;
        end
    end
endmodule

// File: rtl/cc_snoop.sv
module cc_snoop
    import cc_pkg::*;
#(
    parameter int TAG_W = 9
) (
    input  logic             valid_i,
    input  logic [1:0]       cmd_i,
    input  logic [TAG_W-1:0] snp_tag_i,
    input  logic [TAG_W-1:0] line_tag_i,
    input  logic [1:0]       line_st_i,
    output logic             hold_o,
    output logic             dirty_o,
    output logic [1:0]       st_nxt_o
);
    mesi_e    st;
    bus_cmd_e cmd;

    always_comb begin
        st       = mesi_e'(line_st_i);
        cmd      = bus_cmd_e'(cmd_i);
        hold_o   = valid_i && (st != MESI_I) && (line_tag_i == snp_tag_i)
                   && (cmd != CMD_WB);
        dirty_o  = hold_o && (st == MESI_M) && (cmd != CMD_UPG);
        st_nxt_o = line_st_i;
        if (hold_o) begin
            if (cmd == CMD_RD) begin
                st_nxt_o = MESI_S;
            end else begin
                st_nxt_o = MESI_I;
            end
        end
    end
endmodule

// File: rtl/cc_mesi_cache.sv
module cc_mesi_cache
    import cc_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 4,
    parameter int LINES      = 8
) (
    input  logic                                            clk,
    input  logic                                            rst_n,
    input  logic                                            core_valid_i,
    input  logic                                            core_we_i,
    input  logic [ADDR_W-1:0]                               core_addr_i,
    input  logic [WORD_W-1:0]                               core_wdata_i,
    input  logic [WORD_W/8-1:0]                             core_be_i,
    output logic                                            core_ready_o,
    output logic [WORD_W-1:0]                               core_rdata_o,
    output logic                                            bus_req_o,
    input  logic                                            bus_gnt_i,
    output logic [1:0]                                      bus_cmd_o,
    output logic [ADDR_W-$clog2(WORD_W/8*LINE_WORDS)-1:0]   bus_addr_o,
    output logic [WORD_W*LINE_WORDS-1:0]                    bus_wdata_o,
    input  logic                                            bus_done_i,
    input  logic [WORD_W*LINE_WORDS-1:0]                    bus_rdata_i,
    input  logic                                            bus_shared_i,
    input  logic                                            snp_valid_i,
    input  logic [1:0]                                      snp_cmd_i,
    input  logic [ADDR_W-$clog2(WORD_W/8*LINE_WORDS)-1:0]   snp_addr_i,
    output logic                                            snp_shared_o,
    output logic                                            snp_dirty_o,
    output logic [WORD_W*LINE_WORDS-1:0]                    snp_data_o
);
    localparam int BYTES_W = WORD_W / 8;
    localparam int LINE_W  = WORD_W * LINE_WORDS;
    localparam int BOFF_W  = $clog2(BYTES_W);
    localparam int WOFF_W  = $clog2(LINE_WORDS);
    localparam int OFF_W   = BOFF_W + WOFF_W;
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;

    typedef struct packed {
        ctl_e                              ctl;
        logic                              we;
        logic [ADDR_W-1:0]                 addr;
        logic [WORD_W-1:0]                 wdata;
        logic [BYTES_W-1:0]                be;
        logic [1:0]                        cmd;
        logic [WORD_W-1:0]                 rdata;
        logic                              rsp_sh;
        logic                              rsp_dirty;
        logic [LINE_W-1:0]                 rsp_data;
        logic [LINES-1:0][TAG_W-1:0]       tags;
        logic [LINES-1:0][1:0]             sts;
        logic [LINES-1:0][LINE_W-1:0]      data;
    } regs_t;

    regs_t r_q, r_d;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WOFF_W-1:0] req_word;
    logic [IDX_W-1:0]  snp_idx;
    logic [TAG_W-1:0]  snp_tag;

    assign req_idx  = r_q.addr[OFF_W +: IDX_W];
    assign req_tag  = r_q.addr[OFF_W + IDX_W +: TAG_W];
    assign req_word = r_q.addr[BOFF_W +: WOFF_W];
    assign snp_idx  = snp_addr_i[IDX_W-1:0];
    assign snp_tag  = snp_addr_i[IDX_W +: TAG_W];

    logic             hit, wr_ok, victim;
    logic [1:0]       sel_cmd;
    logic             snp_hold, snp_dirty;
    logic [1:0]       snp_st_nxt;
    logic [LINE_W-1:0] merged;

    cc_cmd_sel #(.TAG_W(TAG_W)) u_sel (
        .line_st_i  (r_q.sts[req_idx]),
        .line_tag_i (r_q.tags[req_idx]),
        .req_tag_i  (req_tag),
        .req_we_i   (r_q.we),
        .hit_o      (hit),
        .writable_o (wr_ok),
        .victim_o   (victim),
        .cmd_o      (sel_cmd)
    );

    cc_snoop #(.TAG_W(TAG_W)) u_snoop (
        .valid_i    (snp_valid_i),
        .cmd_i      (snp_cmd_i),
        .snp_tag_i  (snp_tag),
        .line_tag_i (r_q.tags[snp_idx]),
        .line_st_i  (r_q.sts[snp_idx]),
        .hold_o     (snp_hold),
        .dirty_o    (snp_dirty),
        .st_nxt_o   (snp_st_nxt)
    );

    cc_merge #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_merge (
        .line_i  (r_q.data[req_idx]),
        .word_i  (req_word),
        .wdata_i (r_q.wdata),
        .be_i    (r_q.be),
        .line_o  (merged)
    );

    always_comb begin
        r_d = r_q;
        r_d.rsp_sh    = 1'b0;
        r_d.rsp_dirty = 1'b0;

        case (r_q.ctl)
            ST_IDLE: begin
                if (core_valid_i) begin
                    r_d.we    = core_we_i;
                    r_d.addr  = core_addr_i;
                    r_d.wdata = core_wdata_i;
                    r_d.be    = core_be_i;
                    r_d.ctl   = ST_LOOK;
                end
            end
            ST_LOOK: begin
                if (!snp_valid_i) begin
                    if (hit && !r_q.we) begin
                        r_d.rdata = r_q.data[req_idx][req_word*WORD_W +: WORD_W];
                        r_d.ctl   = ST_RESP;
                    end else if (wr_ok && r_q.we) begin
                        r_d.data[req_idx] = merged;
                        r_d.sts[req_idx]  = MESI_M;
                        r_d.ctl           = ST_RESP;
                    end else begin
                        r_d.ctl = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (bus_gnt_i) begin
                    r_d.cmd = sel_cmd;
                    r_d.ctl = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (bus_done_i) begin
                    case (bus_cmd_e'(r_q.cmd))
                        CMD_WB: r_d.sts[req_idx] = MESI_I;
                        CMD_UPG: r_d.sts[req_idx] = MESI_M;
                        CMD_RD: begin
                            r_d.data[req_idx] = bus_rdata_i;
                            r_d.tags[req_idx] = req_tag;
                            r_d.sts[req_idx]  = bus_shared_i ? MESI_S : MESI_E;
                        end
                        default: begin
                            r_d.data[req_idx] = bus_rdata_i;
                            r_d.tags[req_idx] = req_tag;
                            r_d.sts[req_idx]  = MESI_M;
                        end
                    endcase
                    r_d.ctl = ST_LOOK;
                end
            end
            default: r_d.ctl = ST_IDLE;
        endcase

        if (snp_valid_i) begin
            r_d.rsp_sh       = snp_hold;
            r_d.rsp_dirty    = snp_dirty;
            r_d.rsp_data     = r_q.data[snp_idx];
            r_d.sts[snp_idx] = snp_st_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign core_ready_o = (r_q.ctl == ST_RESP);
    assign core_rdata_o = r_q.rdata;
    assign bus_req_o    = (r_q.ctl == ST_REQ);
    assign bus_cmd_o    = sel_cmd;
    assign bus_addr_o   = victim ? {r_q.tags[req_idx], req_idx} : {req_tag, req_idx};
    assign bus_wdata_o  = r_q.data[req_idx];
    assign snp_shared_o = r_q.rsp_sh;
    assign snp_dirty_o  = r_q.rsp_dirty;
    assign snp_data_o   = r_q.rsp_data;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_gnt_i) |=> bus_req_o);

    // R6
    dirty_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_dirty_o |-> snp_shared_o);

    // R6
    snoop_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared_o |-> $past(snp_valid_i));

    // R4
    silent_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ctl == ST_LOOK && r_q.we && wr_ok && !snp_valid_i)
        |=> (core_ready_o && !bus_req_o));

    // R5
    no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_gnt_i) |=> !core_ready_o);
endmodule

// File: tb/tb_cc_mesi_cache.sv
module tb_cc_mesi_cache;
    localparam int CLK_PERIOD = 10;
    localparam int LB = 16;

    typedef struct {
        bit          ld;
        logic [31:0] v;
        string       r;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic         cv[2], cwe[2], crdy[2];
    logic [15:0]  ca[2];
    logic [31:0]  cwd[2], crd[2];
    logic [3:0]   cbe[2];
    logic         breq[2], bgnt[2], bdone[2], bsh[2];
    logic [1:0]   bcmd[2];
    logic [11:0]  baddr[2];
    logic [127:0] bwd[2], brd[2];
    logic         sv[2], ssh[2], sdt[2];
    logic [1:0]   sc[2];
    logic [11:0]  sa[2];
    logic [127:0] sdat[2];

    int checks = 0, errors = 0;
    int cnt[2];
    int dirty_cnt[2];
    logic [1:0] hist[2][64];
    logic [127:0] mem [int];
    logic [31:0]  wref [int];
    item_t q0[$], q1[$];
    int rr = 0;

    cc_mesi_cache dut (
        .clk(clk), .rst_n(rst_n),
        .core_valid_i(cv[0]), .core_we_i(cwe[0]), .core_addr_i(ca[0]),
        .core_wdata_i(cwd[0]), .core_be_i(cbe[0]), .core_ready_o(crdy[0]),
        .core_rdata_o(crd[0]), .bus_req_o(breq[0]), .bus_gnt_i(bgnt[0]),
        .bus_cmd_o(bcmd[0]), .bus_addr_o(baddr[0]), .bus_wdata_o(bwd[0]),
        .bus_done_i(bdone[0]), .bus_rdata_i(brd[0]), .bus_shared_i(bsh[0]),
        .snp_valid_i(sv[0]), .snp_cmd_i(sc[0]), .snp_addr_i(sa[0]),
        .snp_shared_o(ssh[0]), .snp_dirty_o(sdt[0]), .snp_data_o(sdat[0])
    );

    cc_mesi_cache peer (
        .clk(clk), .rst_n(rst_n),
        .core_valid_i(cv[1]), .core_we_i(cwe[1]), .core_addr_i(ca[1]),
        .core_wdata_i(cwd[1]), .core_be_i(cbe[1]), .core_ready_o(crdy[1]),
        .core_rdata_o(crd[1]), .bus_req_o(breq[1]), .bus_gnt_i(bgnt[1]),
        .bus_cmd_o(bcmd[1]), .bus_addr_o(baddr[1]), .bus_wdata_o(bwd[1]),
        .bus_done_i(bdone[1]), .bus_rdata_i(brd[1]), .bus_shared_i(bsh[1]),
        .snp_valid_i(sv[1]), .snp_cmd_i(sc[1]), .snp_addr_i(sa[1]),
        .snp_shared_o(ssh[1]), .snp_dirty_o(sdt[1]), .snp_data_o(sdat[1])
    );

    function automatic logic [31:0] init_word(input logic [15:0] a);
        return 32'hC0DE_0000 | {16'h0, a & 16'hFFFC};
    endfunction

    function automatic logic [127:0] memrd(input logic [11:0] la);
        logic [127:0] l;
        if (mem.exists(int'(la))) return mem[int'(la)];
        for (int k = 0; k < 4; k++) l[k*32 +: 32] = init_word({la, 4'h0} + 16'(k*4));
        return l;
    endfunction

    function automatic logic [31:0] ref_rd(input logic [15:0] a);
        int key = int'(a >> 2);
        return wref.exists(key) ? wref[key] : init_word(a);
    endfunction

    task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", r, act, exp);
        end
    endtask

    // Bus arbiter and memory
    initial begin
        for (int c = 0; c < 2; c++) begin
            bgnt[c] = 0; bdone[c] = 0; bsh[c] = 0; brd[c] = '0;
            sv[c] = 0; sc[c] = 0; sa[c] = '0; cnt[c] = 0; dirty_cnt[c] = 0;
        end
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (breq[0] || breq[1]) begin
                int w, o;
                logic [1:0] cm;
                logic [11:0] la;
                logic [127:0] wd;
                w = (breq[0] && (!breq[1] || rr == 0)) ? 0 : 1;
                o = 1 - w;
                rr = o;
                cm = bcmd[w]; la = baddr[w]; wd = bwd[w];
                hist[w][cnt[w] % 64] = cm;
                cnt[w]++;
                bgnt[w] = 1; sv[o] = 1; sc[o] = cm; sa[o] = la;
                @(negedge clk);
                bgnt[w] = 0; sv[o] = 0;
                if (sdt[o]) dirty_cnt[o]++;
                if (cm == 2'b11) begin
                    mem[int'(la)] = wd;
                end else if (cm != 2'b10) begin
                    if (sdt[o]) mem[int'(la)] = sdat[o];
                    brd[w] = sdt[o] ? sdat[o] : memrd(la);
                end
                bsh[w] = ssh[o];
                bdone[w] = 1;
                @(negedge clk);
                bdone[w] = 0;
            end
        end
    end

    task automatic access(input int c, input bit we, input logic [15:0] a,
                          input logic [31:0] wd, input logic [3:0] be, input string r);
        item_t it;
        it.ld = !we; it.r = r; it.v = ref_rd(a);
        if (we) begin
            logic [31:0] nv = ref_rd(a);
            for (int b = 0; b < 4; b++) if (be[b]) nv[b*8 +: 8] = wd[b*8 +: 8];
            wref[int'(a >> 2)] = nv;
        end
        if (c == 0) q0.push_back(it); else q1.push_back(it);
        @(negedge clk);
        cv[c] = 1; cwe[c] = we; ca[c] = a; cwd[c] = wd; cbe[c] = be;
        do @(negedge clk); while (!crdy[c]);
        cv[c] = 0;
        @(negedge clk);
        chk(crdy[c] == 1'b0, "R11 ready pulse width", crdy[c], 0);
    endtask

    // Monitor: pops expected items on each completion
    always @(negedge clk) begin
        for (int c = 0; c < 2; c++) begin
            if (rst_n && crdy[c]) begin
                item_t it;
                if (c == 0) it = q0.pop_front(); else it = q1.pop_front();
                if (it.ld) chk(crd[c] == it.v, it.r, crd[c], it.v);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] A, B, C, E;
        int n, n1, d;
        A = 16'h0100; B = 16'h0180; C = 16'h0040; E = 16'h0250;
        for (int c = 0; c < 2; c++) begin
            cv[c] = 0; cwe[c] = 0; ca[c] = '0; cwd[c] = '0; cbe[c] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!crdy[0] && !crdy[1], "R1 ready low after reset", {crdy[0], crdy[1]}, 0);
        chk(!breq[0] && !breq[1], "R1 bus_req low after reset", {breq[0], breq[1]}, 0);

        n = cnt[0];
        access(0, 0, A, 0, 0, "R2 load miss data");
        chk(cnt[0] == n + 1 && hist[0][n % 64] == 2'b00, "R1 R2 miss issues read", hist[0][n % 64], 0);

        n = cnt[0];
        access(0, 0, A + 4, 0, 0, "R2 same-line hit data");
        chk(cnt[0] == n, "R2 same line no bus traffic", cnt[0] - n, 0);

        n = cnt[0];
        access(0, 1, A + 8, 32'h1234_5678, 4'hF, "R4");
        chk(cnt[0] == n, "R3 R4 store to E fill silent", cnt[0] - n, 0);
        access(0, 0, A + 8, 0, 0, "R4 store visible locally");

        d = dirty_cnt[0]; n1 = cnt[1];
        access(1, 0, A + 8, 0, 0, "R7 peer reads dirty data");
        chk(dirty_cnt[0] == d + 1, "R6 dirty supply on snooped read", dirty_cnt[0] - d, 1);
        chk(cnt[1] == n1 + 1 && hist[1][n1 % 64] == 2'b00, "R2 peer read", hist[1][n1 % 64], 0);

        n = cnt[0];
        access(0, 1, A, 32'h0000_BEEF, 4'b0011, "R9");
        chk(cnt[0] == n + 1 && hist[0][n % 64] == 2'b10, "R5 R7 store to S upgrades", hist[0][n % 64], 2'b10);

        n1 = cnt[1];
        access(1, 0, A, 0, 0, "R9 partial bytes merged");
        chk(cnt[1] == n1 + 1, "R7 snooped upgrade invalidated peer", cnt[1] - n1, 1);

        n1 = cnt[1];
        access(1, 1, C, 32'hAAAA_5555, 4'hF, "R5");
        chk(hist[1][n1 % 64] == 2'b01, "R5 store miss read-for-ownership", hist[1][n1 % 64], 2'b01);
        access(1, 0, C, 0, 0, "R5 stored value after ownership");
        n1 = cnt[1];
        access(1, 1, C + 4, 32'h0F0F_0F0F, 4'hF, "R4");
        chk(cnt[1] == n1, "R4 store to M silent", cnt[1] - n1, 0);

        access(0, 1, A + 12, 32'hFACE_CAFE, 4'hF, "R5");
        n = cnt[0];
        access(0, 0, B, 0, 0, "R8 new line after eviction");
        chk(cnt[0] == n + 2 && hist[0][n % 64] == 2'b11 && hist[0][(n+1) % 64] == 2'b00,
            "R8 write-back then read", {hist[0][n % 64], hist[0][(n+1) % 64]}, 4'b1100);
        chk(memrd(A >> 4) == {ref_rd(A + 12), ref_rd(A + 8), ref_rd(A + 4), ref_rd(A)},
            "R8 victim line in memory", memrd(A >> 4),
            {ref_rd(A + 12), ref_rd(A + 8), ref_rd(A + 4), ref_rd(A)});

        access(0, 0, C + 4, 0, 0, "R7 read of peer M line");
        n = cnt[0];
        access(0, 1, C, 32'h0000_0077, 4'b0001, "R9");
        chk(hist[0][n % 64] == 2'b10, "R3 shared fill needs upgrade", hist[0][n % 64], 2'b10);
        access(1, 0, C, 0, 0, "R7 peer rereads after upgrade");

        access(0, 0, E, 0, 0, "R2 race line load");
        access(1, 0, E, 0, 0, "R2 race line peer load");
        n = cnt[0]; n1 = cnt[1];
        fork
            access(0, 1, E, 32'h0000_0011, 4'b0001, "R10");
            access(1, 1, E, 32'h0022_0000, 4'b0100, "R10");
        join
        chk(cnt[0] == n + 1 && cnt[1] == n1 + 1 &&
            ({hist[0][n % 64], hist[1][n1 % 64]} == 4'b1001 ||
             {hist[0][n % 64], hist[1][n1 % 64]} == 4'b0110),
            "R10 stale upgrade turned ownership read",
            {hist[0][n % 64], hist[1][n1 % 64]}, 4'b1001);
        access(0, 0, E, 0, 0, "R10 merged race result");
        access(1, 0, E, 0, 0, "R10 merged race result peer");

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule